// File: doc/BRIEF.md
# PWM and Pulse-Capture Timer

This block is a single timer channel with two exclusive modes, picked by one mode input. In generation mode it drives a rectangular waveform on `pwm_out`. Each period lasts a programmed number of clock cycles. The output is high for the first part of the period, for a programmed number of cycles, and low for the rest. New period and width settings are picked up only at a period boundary, so a change never cuts or stretches a pulse in the middle of a period.

In capture mode the channel measures a waveform on `cap_in`. It reports two values: the period, taken between successive rising edges, and the width of either the high pulse or the low pulse, as chosen by `hi_sel`. Both values are copied to holding outputs only when a full measurement is complete. An event strobe marks every period end in generation mode and every completed capture in capture mode.

The counters are `W` bits wide and saturate at all ones. Saturation sets a sticky overflow flag. The default width of 32 bits covers periods of tens of seconds at core clock rates.

Top module: `pwm_capture_timer`

## Requirements
- R1: While reset is asserted, and right after it, `pwm_out`, `evt` and `ovf` are 0, and `cap_period` and `cap_width` are 0.
- R2: In generation mode (`en`=1, `mode`=0), the waveform repeats every P cycles, where P is the active period. A period of 0 or 1 acts as a one-cycle period. `pwm_out` is high in the first D cycles of each period, where D is the active width, and low for the rest. The first period starts in the cycle after `en` is sampled high.
- R3: An active width of 0 keeps `pwm_out` low for the whole time. An active width equal to or greater than the period keeps it high for the whole time.
- R4: Values on `period_in` and `width_in` become active at the edge that starts a period, including the first period after enable. Changes made in the middle of a period do not affect that period.
- R5: In generation mode, `evt` is high for exactly one cycle: the first cycle of each period that follows a completed period.
- R6: In capture mode (`en`=1, `mode`=1), `cap_in` passes through a two-flop synchronizer. `cap_period` receives the number of clock cycles between two successive detected rising edges. The holding outputs change three clock edges after the input edge that completes the measurement.
- R7: With `hi_sel`=1, `cap_width` receives the number of cycles from a rising edge to the next falling edge. With `hi_sel`=0, it receives the number of cycles from a falling edge to the next rising edge. `hi_sel` is sampled when the measurement completes. `cap_width` never exceeds `cap_period`.
- R8: The holding outputs change only at a rising edge that closes a period in which a falling edge was also seen. The first rising edge after capture is enabled only arms the channel. `evt` is high in the same cycle that the holding outputs change.
- R9: When a period measurement reaches 2^W-1 cycles, the reported values stay at 2^W-1 and `ovf` becomes 1. `ovf` stays 1 while capture mode remains enabled. Leaving capture mode clears it.
- R10: With `en`=0, `pwm_out` is low, `evt` stays low, and the holding outputs keep their values.
- R11: In capture mode `pwm_out` is low. In generation mode `cap_period`, `cap_width` and `ovf` do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Channel enable |
| mode | input | 1 | 0 = pulse generation, 1 = capture |
| hi_sel | input | 1 | Capture: 1 = measure high pulse, 0 = measure low pulse |
| period_in | input | W | Generation period in cycles |
| width_in | input | W | Generation high time in cycles |
| cap_in | input | 1 | Waveform to be measured (asynchronous) |
| pwm_out | output | 1 | Generated waveform |
| evt | output | 1 | One-cycle event strobe |
| cap_period | output | W | Last captured period |
| cap_width | output | W | Last captured pulse width |
| ovf | output | 1 | Sticky capture overflow flag |

## Verification
In generation mode, `pwm_out` and `evt` reflect the edge at which an input was sampled, so they are due one edge after the stimulus. Capture results and the capture event are due at the third edge after `cap_in` changes: two edges fill the synchronizer and a third detects the edge and latches the result. The bench drives every input on the falling clock edge. A timestamp-based model advances on each rising edge and computes what every output should read after that edge. All five outputs are then compared against the model at the following falling edge, so each expected value is taken in the cycle its registers make it due.

// File: rtl/pwm_capture_timer.sv
module pwm_capture_timer #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         mode,
  input  logic         hi_sel,
  input  logic [W-1:0] period_in,
  input  logic [W-1:0] width_in,
  input  logic         cap_in,
  output logic         pwm_out,
  output logic         evt,
  output logic [W-1:0] cap_period,
  output logic [W-1:0] cap_width,
  output logic         ovf
);
  localparam logic [W-1:0] TOP = '1;
  localparam logic [W-1:0] ONE = W'(1);

  logic gen_go, cap_go;
  assign gen_go = en & ~mode;
  assign cap_go = en & mode;

  logic         run;
  logic [W-1:0] cnt, per_q, wid_q;
  logic [W:0]   nxt;
  logic         bnd;

  assign nxt = {1'b0, cnt} + {{W{1'b0}}, 1'b1};
  assign bnd = run & gen_go & (nxt >= {1'b0, per_q});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= 1'b0;
      cnt   <= '0;
      per_q <= '0;
      wid_q <= '0;
    end else if (!gen_go) begin
      run   <= 1'b0;
      cnt   <= '0;
      per_q <= period_in;
      wid_q <= width_in;
    end else if (!run || bnd) begin
      run   <= 1'b1;
      cnt   <= '0;
      per_q <= period_in;
      wid_q <= width_in;
    end else begin
      cnt <= nxt[W-1:0];
    end
  end

  assign pwm_out = run & (cnt < wid_q);

  logic [2:0] sync;
  logic       rise, fall;
  assign rise = sync[1] & ~sync[2];
  assign fall = ~sync[1] & sync[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= '0;
    else        sync <= {sync[1:0], cap_in};
  end

  logic         armed, got_fall, done;
  logic [W-1:0] pcnt, fcnt, hi_q;

  assign done = cap_go & rise & armed & got_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      got_fall <= 1'b0;
      pcnt     <= '0;
      fcnt     <= '0;
      hi_q     <= '0;
      ovf      <= 1'b0;
    end else if (!cap_go) begin
      armed    <= 1'b0;
      got_fall <= 1'b0;
      pcnt     <= '0;
      fcnt     <= '0;
      ovf      <= 1'b0;
    end else begin
      pcnt <= rise ? ONE : ((pcnt == TOP) ? TOP : pcnt + ONE);
      fcnt <= fall ? ONE : ((fcnt == TOP) ? TOP : fcnt + ONE);
      if (armed && !rise && pcnt == TOP) ovf <= 1'b1;
      if (rise) begin
        armed    <= 1'b1;
        got_fall <= 1'b0;
      end else if (fall && armed) begin
        got_fall <= 1'b1;
        hi_q     <= pcnt;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_period <= '0;
      cap_width  <= '0;
      evt        <= 1'b0;
    end else begin
      evt <= bnd | done;
      if (done) begin
        cap_period <= pcnt;
        cap_width  <= hi_sel ? hi_q : fcnt;
      end
    end
  end
endmodule

module pwm_capture_timer_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic         mode,
  input logic         pwm_out,
  input logic         evt,
  input logic [W-1:0] cap_period,
  input logic [W-1:0] cap_width,
  input logic         ovf
);
  a_r10_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!pwm_out && !evt));

  a_r11_capture_no_pwm: assert property (@(posedge clk) disable iff (!rst_n)
    mode |=> !pwm_out);

  a_r8_hold_with_evt: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(cap_period) || !$stable(cap_width)) |-> evt);

  a_r7_width_in_period: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cap_width) |-> (cap_width <= cap_period));

  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && en && mode) |=> ovf);

  a_r11_gen_keeps_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode && !ovf) |=> !ovf);
endmodule

bind pwm_capture_timer pwm_capture_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .pwm_out(pwm_out),
  .evt(evt), .cap_period(cap_period), .cap_width(cap_width), .ovf(ovf)
);

// File: tb/test_pwm_capture_timer.sv
module test_pwm_capture_timer;
  localparam int W   = 8;
  localparam int MAX = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         en = 1'b0, mode = 1'b0, hi_sel = 1'b0, cap_in = 1'b0;
  logic [W-1:0] period_in = '0, width_in = '0;
  logic         pwm_out, evt, ovf;
  logic [W-1:0] cap_period, cap_width;

  always #4 clk = ~clk;

  pwm_capture_timer #(.W(W)) i_pwm_capture_timer (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .hi_sel(hi_sel),
    .period_in(period_in), .width_in(width_in), .cap_in(cap_in),
    .pwm_out(pwm_out), .evt(evt), .cap_period(cap_period),
    .cap_width(cap_width), .ovf(ovf)
  );

  int    n_chk = 0, n_bad = 0;
  string gtag = "R1";
  bit    live = 0, finished = 0;

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int sat(int v);
    return (v > MAX) ? MAX : v;
  endfunction

  int cyc, g_ph, g_per, g_wid, t_r, t_f, e_per, e_wid;
  bit g_run, h0, h1, h2, armed, gotf, e_ovf, e_evt, e_pwm;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc = 0; g_run = 0; g_ph = 0; g_per = 0; g_wid = 0;
      h0 = 0; h1 = 0; h2 = 0; armed = 0; gotf = 0; t_r = 0; t_f = 0;
      e_per = 0; e_wid = 0; e_ovf = 0; e_evt = 0; e_pwm = 0;
    end else begin
      bit gevt, cevt, up, dn;
      cyc++;
      gevt = 0; cevt = 0;
      if (!(en && !mode)) begin
        g_run = 0; g_ph = 0; g_per = int'(period_in); g_wid = int'(width_in);
      end else if (!g_run || g_ph + 1 >= g_per) begin
        gevt = g_run;
        g_run = 1; g_ph = 0; g_per = int'(period_in); g_wid = int'(width_in);
      end else begin
        g_ph++;
      end
      up = h1 && !h2;
      dn = !h1 && h2;
      if (!(en && mode)) begin
        armed = 0; gotf = 0; e_ovf = 0;
      end else begin
        if (armed && !up && (cyc - t_r) >= MAX) e_ovf = 1;
        if (up) begin
          if (armed && gotf) begin
            e_per = sat(cyc - t_r);
            e_wid = hi_sel ? sat(t_f - t_r) : sat(cyc - t_f);
            cevt  = 1;
          end
          armed = 1; gotf = 0; t_r = cyc;
        end else if (dn && armed) begin
          gotf = 1; t_f = cyc;
        end
      end
      h2 = h1; h1 = h0; h0 = cap_in;
      e_pwm = g_run && (g_ph < g_wid);
      e_evt = gevt || cevt;
    end
  end

  always @(negedge clk) begin
    if (live) begin
      chk(gtag, "pwm_out", int'(pwm_out), int'(e_pwm));
      chk(mode ? "R8" : "R5", "evt", int'(evt), int'(e_evt));
      chk("R6", "cap_period", int'(cap_period), e_per);
      chk("R7", "cap_width", int'(cap_width), e_wid);
      chk("R9", "ovf", int'(ovf), int'(e_ovf));
    end
  end

  task automatic wait_n(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic wave(int hi, int lo, int reps);
    for (int i = 0; i < reps; i++) begin
      cap_in = 1'b1; wait_n(hi);
      cap_in = 1'b0; wait_n(lo);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    wait_n(3);
    chk("R1", "pwm_out in reset", int'(pwm_out), 0);
    chk("R1", "evt in reset", int'(evt), 0);
    chk("R1", "cap_period in reset", int'(cap_period), 0);
    chk("R1", "ovf in reset", int'(ovf), 0);
    rst_n = 1'b1;
    wait_n(1);
    chk("R1", "cap_width after reset", int'(cap_width), 0);
    live = 1;

    gtag = "R2"; period_in = 8'd10; width_in = 8'd3; en = 1'b1;
    wait_n(35);
    gtag = "R4"; period_in = 8'd6; width_in = 8'd4;
    wait_n(30);
    gtag = "R3"; width_in = 8'd0;
    wait_n(20);
    period_in = 8'd5; width_in = 8'd8;
    wait_n(20);
    period_in = 8'd1; width_in = 8'd1;
    wait_n(8);
    period_in = 8'd0; width_in = 8'd0;
    wait_n(8);
    gtag = "R2"; period_in = 8'd7; width_in = 8'd2;
    wait_n(25);

    gtag = "R10"; en = 1'b0;
    wait_n(12);

    gtag = "R11"; mode = 1'b1; en = 1'b1; hi_sel = 1'b1;
    wave(4, 7, 4);
    hi_sel = 1'b0;
    wave(5, 2, 4);
    wave(3, 9, 3);
    hi_sel = 1'b1;
    wave(300, 3, 1);
    wave(2, 4, 2);
    en = 1'b0;
    wait_n(6);
    en = 1'b1;
    wave(6, 6, 3);

    gtag = "R11"; mode = 1'b0; period_in = 8'd9; width_in = 8'd4;
    wave(3, 5, 4);
    gtag = "R10"; en = 1'b0;
    wave(2, 2, 3);
    wait_n(4);

    live = 0;
    finished = 1;
    finish_run();
  end
endmodule